// File: doc/BRIEF.md
# Card Clock Divider with Update Handshake

This block generates the card clock of a memory-card host from the host's input clock. Software programs four registers: a divider value, a source selection, an enable word and a command word. A write to the divider, source or enable register only changes a shadow copy, and the running clock does not change. The new settings reach the live divider only when software issues an update command. The command's start bit reads back as 1 until the block has taken the new settings on.

The update lands only while the card clock is low, so no shortened high pulse can reach the card. A wait option holds the update while a data transfer is still in progress. A low-power option stops the clock after a fixed number of input cycles with no command or data activity, and restarts it as soon as activity returns.

The card clock is given as a level (`cclk`) and as a one-cycle strobe (`cclk_stb`) that marks each rising edge of the card clock. A divider value D of 1 or more gives a card-clock period of 2·D input cycles. Software picks D as the ceiling of the input rate divided by twice the target rate. D = 0 selects bypass: the strobe is then high on every input cycle and `cclk` stays low.

Top module: `cardclk_gen`

## Requirements
- R1: After a synchronous reset, `cclk` and `cclk_stb` are 0, the start bit (bit 31 of the command register readback, address 3) is 0, `act_div` and `act_src` are 0, and the clock is disabled.
- R2: Writes to the divider register (address 0), the source register (address 1) or the enable register (address 2) do not change `act_div`, `act_src` or the card-clock period until an update command is applied.
- R3: A write to address 3 with bit 31 (start) and bit 1 (update-clock-only) both set makes the start bit read 1. The start bit returns to 0 in the cycle after the shadow settings are loaded into the live divider.
- R4: With D ≥ 1 and the clock enabled, when the update is accepted on a low card clock, the first `cclk_stb` appears D+1 cycles after the command write edge. Later strobes follow every 2·D cycles.
- R5: With D = 0 (bypass) and the clock enabled, `cclk_stb` is high on every cycle from the second cycle after the command write edge, and `cclk` stays 0.
- R6: New settings are loaded only while `cclk` is low. An update issued while `cclk` is high leaves the start bit at 1 until `cclk` falls.
- R7: When bit 0 (wait-for-previous-data) of the update command is set, the update is held while `data_busy` is 1 and proceeds once it drops. Without that bit, the update proceeds even while `data_busy` is 1.
- R8: A write to address 3 with bit 31 set but bit 1 clear is ignored: the start bit stays 0 and the live settings do not change.
- R9: With enable-register bit 1 (low power) applied, after 16 cycles without `cmd_busy` or `data_busy` the clock stops with `cclk` low. Raising `cmd_busy` restarts it. With low power clear, the clock keeps running while idle.
- R10: With enable-register bit 0 clear after an update, `cclk_stb` and `cclk` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 divider, 1 source, 2 enable, 3 command |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data (shadow registers; start bit at address 3) |
| cmd_busy | input | 1 | Command path active (for idle detection) |
| data_busy | input | 1 | Data path active (idle detection and update hold) |
| cclk | output | 1 | Card clock level |
| cclk_stb | output | 1 | One-cycle strobe at each card-clock rising edge |
| act_div | output | 8 | Divider currently in effect |
| act_src | output | 2 | Source selection currently in effect |

## Verification
The following are checked on every cycle:
- Settings are loaded only while the card clock is low.
- The start bit clears only through a load.
- A held update stays pending while the data path is busy.
- Each rise of the card clock comes with its strobe.
- A gated or bypassed clock keeps its level low.

Only the bench's scenarios can show the following:
- The exact latency and period for each divider value.
- That shadow writes and malformed commands leave the running clock alone.
- That low-power gating stops the clock and restarts it on activity.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  typedef enum logic [1:0] {
    SEL_DIV = 2'd0,
    SEL_SRC = 2'd1,
    SEL_ENA = 2'd2,
    SEL_CMD = 2'd3
  } reg_sel_e;

  localparam int ENA_ON_BIT    = 0;
  localparam int ENA_LP_BIT    = 1;
  localparam int CMD_WAIT_BIT  = 0;
  localparam int CMD_UPD_BIT   = 1;
  localparam int CMD_START_BIT = 31;
endpackage

// File: rtl/ccg_regs.sv
module ccg_regs
  import ccg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_addr,
  input  logic             data_busy,
  input  logic             cclk_low,
  output logic [31:0]      rd_data,
  output logic [DIV_W-1:0] sh_div,
  output logic [SRC_W-1:0] sh_src,
  output logic             sh_en,
  output logic             sh_lp,
  output logic             load
);
  logic pend_q, wait_q;

  // Update is taken once pending, not held by busy data, and card clock low.
  assign load = pend_q && !(wait_q && data_busy) && cclk_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_div <= '0;
      sh_src <= '0;
      sh_en  <= 1'b0;
      sh_lp  <= 1'b0;
      pend_q <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      if (load) pend_q <= 1'b0;
      if (wr_en) begin
        case (reg_sel_e'(wr_addr))
          SEL_DIV: sh_div <= wr_data[DIV_W-1:0];
          SEL_SRC: sh_src <= wr_data[SRC_W-1:0];
          SEL_ENA: begin
            sh_en <= wr_data[ENA_ON_BIT];
            sh_lp <= wr_data[ENA_LP_BIT];
          end
          default: begin
            if (wr_data[CMD_START_BIT] && wr_data[CMD_UPD_BIT]) begin
              pend_q <= 1'b1;
              wait_q <= wr_data[CMD_WAIT_BIT];
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel_e'(rd_addr))
      SEL_DIV: rd_data = 32'(sh_div);
      SEL_SRC: rd_data = 32'(sh_src);
      SEL_ENA: rd_data = {30'd0, sh_lp, sh_en};
      default: rd_data = {pend_q, 31'd0};
    endcase
  end

  // R3: start bit only drops through a load of the settings
  a_r3_pend_until_load: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> $past(load));
  // R7: a held update stays pending while data is busy
  a_r7_wait_hold: assert property (@(posedge clk) disable iff (rst)
    (pend_q && wait_q && data_busy) |=> pend_q);
endmodule

// File: rtl/ccg_divider.sv
module ccg_divider #(
  parameter int DIV_W    = 8,
  parameter int SRC_W    = 2,
  parameter int IDLE_CYC = 16,
  localparam int IDLE_W  = $clog2(IDLE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] sh_div,
  input  logic [SRC_W-1:0] sh_src,
  input  logic             sh_en,
  input  logic             sh_lp,
  input  logic             cmd_busy,
  input  logic             data_busy,
  output logic             cclk,
  output logic             cclk_stb,
  output logic [DIV_W-1:0] act_div,
  output logic [SRC_W-1:0] act_src
);
  logic              en_q, lp_q, cclk_q, stb_q, gated_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [IDLE_W-1:0] idle_q;
  logic              run, bypass, toggle_now, activity;

  assign run        = en_q && !gated_q;
  assign bypass     = (act_div == '0);
  assign toggle_now = !bypass && (cnt_q == act_div - DIV_W'(1));
  assign activity   = cmd_busy || data_busy;

  // Idle detection and low-power gating
  always_ff @(posedge clk) begin
    if (rst || load) begin
      idle_q  <= '0;
      gated_q <= 1'b0;
    end else if (activity || !lp_q) begin
      idle_q  <= '0;
      gated_q <= 1'b0;
    end else begin
      if (idle_q != IDLE_W'(IDLE_CYC)) idle_q <= idle_q + IDLE_W'(1);
      else if (!cclk_q && !(run && toggle_now)) gated_q <= 1'b1;
    end
  end

  // Live settings and the counter
  always_ff @(posedge clk) begin
    if (rst) begin
      act_div <= '0;
      act_src <= '0;
      en_q    <= 1'b0;
      lp_q    <= 1'b0;
      cnt_q   <= '0;
      cclk_q  <= 1'b0;
      stb_q   <= 1'b0;
    end else if (load) begin
      act_div <= sh_div;
      act_src <= sh_src;
      en_q    <= sh_en;
      lp_q    <= sh_lp;
      cnt_q   <= '0;
      cclk_q  <= 1'b0;
      stb_q   <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      cclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else if (bypass) begin
      cnt_q  <= '0;
      cclk_q <= 1'b0;
      stb_q  <= 1'b1;
    end else if (toggle_now) begin
      cnt_q  <= '0;
      cclk_q <= !cclk_q;
      stb_q  <= !cclk_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
      stb_q <= 1'b0;
    end
  end

  assign cclk     = cclk_q;
  assign cclk_stb = stb_q;

  // R6: settings arrive only while the card clock is low
  a_r6_load_low: assert property (@(posedge clk) disable iff (rst)
    load |-> !cclk_q);
  // R4: every rise of the card clock carries its strobe
  a_r4_rise_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(cclk_q) |-> stb_q);
  // R9: a gated clock is held low
  a_r9_gate_low: assert property (@(posedge clk) disable iff (rst)
    gated_q |-> !cclk_q);
  // R5: bypass keeps the level output low
  a_r5_bypass_low: assert property (@(posedge clk) disable iff (rst)
    (en_q && bypass && !load) |=> !cclk_q);
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen #(
  parameter int DIV_W    = 8,
  parameter int SRC_W    = 2,
  parameter int IDLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_addr,
  output logic [31:0]      rd_data,
  input  logic             cmd_busy,
  input  logic             data_busy,
  output logic             cclk,
  output logic             cclk_stb,
  output logic [DIV_W-1:0] act_div,
  output logic [SRC_W-1:0] act_src
);
  logic [DIV_W-1:0] sh_div;
  logic [SRC_W-1:0] sh_src;
  logic             sh_en, sh_lp, load;

  ccg_regs #(.DIV_W(DIV_W), .SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .data_busy(data_busy), .cclk_low(!cclk),
    .rd_data(rd_data), .sh_div(sh_div), .sh_src(sh_src), .sh_en(sh_en),
    .sh_lp(sh_lp), .load(load)
  );

  ccg_divider #(.DIV_W(DIV_W), .SRC_W(SRC_W), .IDLE_CYC(IDLE_CYC)) u_div (
    .clk(clk), .rst(rst), .load(load), .sh_div(sh_div), .sh_src(sh_src),
    .sh_en(sh_en), .sh_lp(sh_lp), .cmd_busy(cmd_busy), .data_busy(data_busy),
    .cclk(cclk), .cclk_stb(cclk_stb), .act_div(act_div), .act_src(act_src)
  );
endmodule

// File: tb/sim_cardclk_gen.sv
`timescale 1ns/1ps
module sim_cardclk_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd3;
  logic [31:0] rd_data;
  logic        cmd_busy = 1'b0, data_busy = 1'b0;
  logic        cclk, cclk_stb;
  logic [7:0]  act_div;
  logic [1:0]  act_src;
  int checks = 0, failures = 0;

  localparam logic [31:0] UPD = 32'h8000_0002;
  localparam int NV = 6;
  // {divider, first-strobe latency, strobe period}
  localparam logic [23:0] VEC [NV] = '{
    {8'd1, 8'd2, 8'd2}, {8'd2, 8'd3, 8'd4}, {8'd3, 8'd4, 8'd6},
    {8'd5, 8'd6, 8'd10}, {8'd7, 8'd8, 8'd14}, {8'd0, 8'd2, 8'd1}};

  always #10 clk = ~clk;

  cardclk_gen u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_busy(cmd_busy), .data_busy(data_busy), .cclk(cclk),
    .cclk_stb(cclk_stb), .act_div(act_div), .act_src(act_src));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      if (!rd_data[31]) break;
      @(negedge clk);
    end
  endtask

  task automatic count_to_stb(output int c);
    c = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); c++;
      if (cclk_stb) break;
    end
  endtask

  task automatic count_stb(input int n, output int s);
    s = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cclk_stb) s++;
    end
  endtask

  task automatic stop_clock();
    wr(2'd2, 32'd0); wr(2'd3, UPD); wait_done();
  endtask

  initial begin
    #(20 * 150000);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c, s;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!cclk && !cclk_stb, "R1 clock outputs", int'(cclk_stb), 0);
    chk(!rd_data[31], "R1 start bit", int'(rd_data[31]), 0);
    chk(act_div == 0 && act_src == 0, "R1 live settings", int'(act_div), 0);

    // Vector table: latency and period per divider (R4, R5, R3)
    for (int v = 0; v < NV; v++) begin
      stop_clock();
      d = VEC[v][23:16];
      wr(2'd0, 32'(d));
      wr(2'd2, 32'd1);
      wr(2'd3, UPD);
      chk(rd_data[31], "R3 start set", int'(rd_data[31]), 1);
      count_to_stb(c);
      chk(c == int'(VEC[v][15:8]), d == 0 ? "R5 first strobe" : "R4 first strobe",
          c, int'(VEC[v][15:8]));
      chk(!rd_data[31] && act_div == d, "R3 start cleared", int'(act_div), int'(d));
      count_to_stb(c);
      chk(c == int'(VEC[v][7:0]), d == 0 ? "R5 period" : "R4 period", c, int'(VEC[v][7:0]));
      if (d == 0) chk(!cclk, "R5 level low", int'(cclk), 0);
    end

    // R2: shadow writes leave the running clock alone
    stop_clock();
    wr(2'd0, 32'd3); wr(2'd2, 32'd1); wr(2'd3, UPD); wait_done();
    wr(2'd0, 32'd9); wr(2'd1, 32'd2);
    count_to_stb(c); count_to_stb(c);
    chk(c == 6, "R2 period kept", c, 6);
    chk(act_div == 3 && act_src == 0, "R2 live kept", int'(act_div), 3);
    chk(rd_data[31] == 1'b0, "R2 no start", int'(rd_data[31]), 0);

    // R8: start without the update-only bit is ignored
    wr(2'd3, 32'h8000_0000);
    chk(!rd_data[31], "R8 start ignored", int'(rd_data[31]), 0);
    count_to_stb(c); count_to_stb(c);
    chk(c == 6 && act_div == 3, "R8 settings kept", int'(act_div), 3);

    // R6: update while the clock is high waits for the low phase
    wr(2'd0, 32'd6);
    wr(2'd3, UPD); wait_done();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cclk) break;
    end
    wr(2'd0, 32'd4);
    wr(2'd3, UPD);
    chk(rd_data[31] && cclk, "R6 held while high", int'(rd_data[31]), 1);
    wait_done();
    chk(act_div == 4 && !cclk, "R6 applied on low", int'(act_div), 4);
    chk(act_src == 2, "R2 source applied", int'(act_src), 2);

    // R7: wait-for-previous-data holds the update
    stop_clock();
    data_busy = 1'b1;
    wr(2'd0, 32'd2); wr(2'd2, 32'd1); wr(2'd3, UPD | 32'd1);
    count_stb(10, s);
    chk(rd_data[31] && s == 0, "R7 held while busy", int'(rd_data[31]), 1);
    data_busy = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!rd_data[31] && act_div == 2, "R7 released", int'(rd_data[31]), 0);
    data_busy = 1'b1;
    wr(2'd0, 32'd5); wr(2'd3, UPD); wait_done();
    chk(act_div == 5, "R7 no-wait proceeds", int'(act_div), 5);
    data_busy = 1'b0;

    // R10: disabled clock stays quiet
    stop_clock();
    count_stb(30, s);
    chk(s == 0 && !cclk, "R10 disabled", s, 0);

    // R9: low-power gating, then restart on activity
    wr(2'd0, 32'd2); wr(2'd2, 32'd3); wr(2'd3, UPD); wait_done();
    repeat (40) @(negedge clk);
    count_stb(30, s);
    chk(s == 0 && !cclk, "R9 gated when idle", s, 0);
    cmd_busy = 1'b1;
    count_stb(20, s);
    chk(s > 0, "R9 restart on activity", s, 5);
    cmd_busy = 1'b0;
    stop_clock();
    wr(2'd2, 32'd1); wr(2'd3, UPD); wait_done();
    repeat (40) @(negedge clk);
    count_stb(20, s);
    chk(s > 0, "R9 runs idle without low power", s, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule